// File: doc/BRIEF.md
# Serial GPIO Shift Master

This block drives a three-wire serial pin expander chain. It produces a serial clock that it derives from the peripheral clock, a load strobe that marks the start of every frame, and a serial data output. It also samples a serial data input. Each frame carries one output bit and one input bit for every serial pin slot. The number of slots is eight times a group count that software programs. Between frames the block takes a fresh copy of its output latch and publishes the inputs it has just captured.

Software works through a small word-addressed register port. A control word holds the enable, the group count and the clock divider. A write to the pin value word goes into the output latch. A read of that same word returns the inputs captured in the last complete frame. A readback word returns the output latch. The block sends frames back to back for as long as it is enabled with a non-zero group count. It takes divider and count changes only when a new frame starts.

Top module: `sio_shift_master`

## Requirements
- R1: After synchronous reset the serial clock is high, the load strobe and the serial data output are low, and the control, pin value and readback words all read zero.
- R2: The control word (address 0) keeps only the enable in bit 0, the group count in bits 6 upward (CNT_W bits wide) and the divider in bits 31:16. It reads back the written value with every other bit cleared.
- R3: While frames run, each serial clock half-period lasts divider+1 peripheral clocks, so a full period lasts 2×(divider+1) clocks. A divider of 0 gives half the peripheral clock rate.
- R4: While the enable is clear, or the group count is zero, the serial clock stays high and the load strobe and the data output stay low. Clearing the enable in the middle of a frame ends that frame at once.
- R5: Each frame opens with the load strobe high for one serial clock period, with the serial clock held high. The strobe is never high while the serial clock is low.
- R6: A frame carries N = 8×min(count, MAX_GROUPS) slots. Output latch bits N-1 down to 0 leave most significant first. Each bit appears on the falling serial clock edge and holds through the rising edge.
- R7: The data input is sampled on each rising serial clock edge. The first sample goes into input bit N-1 and the last into bit 0. Input bits at N and above read zero.
- R8: The pin value word (address 1, read) changes only at the end of a complete frame, which is the same edge on which the next load strobe rises. A frame cut short by disabling leaves the word unchanged.
- R9: A write to address 1 sets the output latch on the next clock edge. Address 2 returns the output latch, and address 3 reads zero.
- R10: The divider, the group count and the output latch are sampled when a frame starts. A change made in the middle of a frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_load | output | 1 | Frame load strobe |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data |

## Verification
Two things can land on the same edge: the end of a frame, which publishes the captured inputs and takes new copies of the latch and the control fields, and a register write to the latch or the control word. The bench watches its own model for the clock just before a frame boundary and issues the write so that it lands on that boundary edge. The model expects the write to be ignored by the frame that starts there, and to show up only in the readback and in the frame after. Every output and the read data are compared with this model on every clock, with the read address stepping through all four words.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int DIV_LSB = 16;
    localparam int DIV_W   = 16;
    localparam int CNT_LSB = 6;
    localparam int EN_BIT  = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL     = 2'd0,
        REG_VALUE    = 2'd1,
        REG_READBACK = 2'd2,
        REG_NONE     = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [7:0]       groups;
    } frame_cfg_t;

    function automatic logic [REG_W-1:0] ctrl_mask(int cnt_w);
        logic [REG_W-1:0] m;
        m = '0;
        m[EN_BIT] = 1'b1;
        for (int i = 0; i < cnt_w; i++) m[CNT_LSB + i] = 1'b1;
        m[REG_W-1:DIV_LSB] = '1;
        return m;
    endfunction

endpackage

// File: rtl/sio_clkdiv.sv
module sio_clkdiv
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sio_regs.sv
module sio_regs
    import sio_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int MAX_GROUPS = 4,
    localparam int PINS      = 8 * MAX_GROUPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   in_value,
    output logic [PINS-1:0]   out_latch,
    output frame_cfg_t        cfg,
    output logic              go
);
    localparam logic [REG_W-1:0] MASK = ctrl_mask(CNT_W);

    logic [REG_W-1:0] ctrl_q;
    logic [PINS-1:0]  latch_q;
    logic [CNT_W-1:0] cnt_f;
    reg_sel_e         sel;

    assign sel   = reg_sel_e'(bus_addr);
    assign cnt_f = ctrl_q[CNT_LSB +: CNT_W];

    always_comb begin
        cfg.div    = ctrl_q[DIV_LSB +: DIV_W];
        cfg.groups = (int'(cnt_f) > MAX_GROUPS) ? 8'(MAX_GROUPS) : 8'(cnt_f);
        go         = ctrl_q[EN_BIT] && (cfg.groups != 8'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            latch_q <= '0;
        end else if (bus_we) begin
            if (sel == REG_CTRL)  ctrl_q  <= bus_wdata & MASK;
            if (sel == REG_VALUE) latch_q <= bus_wdata[PINS-1:0];
        end
    end

    assign out_latch = latch_q;

    always_comb begin
        unique case (sel)
            REG_CTRL:     bus_rdata = ctrl_q;
            REG_VALUE:    bus_rdata = REG_W'(in_value);
            REG_READBACK: bus_rdata = REG_W'(latch_q);
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sio_frame.sv
module sio_frame
    import sio_pkg::*;
#(
    parameter int MAX_GROUPS = 4,
    localparam int PINS      = 8 * MAX_GROUPS,
    localparam int IDX_W     = $clog2(PINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  frame_cfg_t       cfg,
    input  logic [PINS-1:0]  out_latch,
    input  logic             tick,
    input  logic             ser_din,
    output logic             run,
    output logic [DIV_W-1:0] div_now,
    output logic             ser_clk,
    output logic             ser_load,
    output logic             ser_dout,
    output logic [PINS-1:0]  in_value
);
    seq_state_e       state_q;
    logic             half_q;
    logic [IDX_W-1:0] bit_q, last_q;
    logic [PINS-1:0]  snap_q, rx_q;
    logic             frame_end, start_now;

    assign run       = (state_q != ST_IDLE);
    assign frame_end = (state_q == ST_SHIFT) && tick && half_q && (bit_q == '0);
    assign start_now = go && ((state_q == ST_IDLE) || frame_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            half_q   <= 1'b0;
            bit_q    <= '0;
            last_q   <= '0;
            snap_q   <= '0;
            rx_q     <= '0;
            div_now  <= '0;
            in_value <= '0;
            ser_clk  <= 1'b1;
            ser_load <= 1'b0;
            ser_dout <= 1'b0;
        end else if (!go) begin
            state_q  <= ST_IDLE;
            ser_clk  <= 1'b1;
            ser_load <= 1'b0;
            ser_dout <= 1'b0;
        end else if (start_now) begin
            if (frame_end) in_value <= rx_q;
            state_q  <= ST_LOAD;
            half_q   <= 1'b0;
            div_now  <= cfg.div;
            last_q   <= IDX_W'(int'(cfg.groups) * 8 - 1);
            snap_q   <= out_latch;
            rx_q     <= '0;
            ser_clk  <= 1'b1;
            ser_load <= 1'b1;
            ser_dout <= 1'b0;
        end else if (tick) begin
            if (state_q == ST_LOAD) begin
                if (!half_q) begin
                    half_q <= 1'b1;
                end else begin
                    state_q  <= ST_SHIFT;
                    half_q   <= 1'b0;
                    bit_q    <= last_q;
                    ser_load <= 1'b0;
                    ser_clk  <= 1'b0;
                    ser_dout <= snap_q[last_q];
                end
            end else if (!half_q) begin
                ser_clk     <= 1'b1;
                rx_q[bit_q] <= ser_din;
                half_q      <= 1'b1;
            end else begin
                bit_q    <= bit_q - 1'b1;
                ser_clk  <= 1'b0;
                ser_dout <= snap_q[bit_q - 1'b1];
                half_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_shift_master.sv
module sio_shift_master
    import sio_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int MAX_GROUPS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        ser_clk,
    output logic        ser_load,
    output logic        ser_dout,
    input  logic        ser_din
);
    localparam int PINS = 8 * MAX_GROUPS;

    frame_cfg_t       cfg;
    logic             go, run, tick;
    logic [PINS-1:0]  out_latch, in_value;
    logic [DIV_W-1:0] div_now;

    sio_regs #(.CNT_W(CNT_W), .MAX_GROUPS(MAX_GROUPS)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_value(in_value),
        .out_latch(out_latch), .cfg(cfg), .go(go)
    );

    sio_clkdiv u_div (
        .clk(clk), .rst(rst), .run(run), .limit(div_now), .tick(tick)
    );

    sio_frame #(.MAX_GROUPS(MAX_GROUPS)) u_frame (
        .clk(clk), .rst(rst), .go(go), .cfg(cfg), .out_latch(out_latch),
        .tick(tick), .ser_din(ser_din), .run(run), .div_now(div_now),
        .ser_clk(ser_clk), .ser_load(ser_load), .ser_dout(ser_dout),
        .in_value(in_value)
    );
endmodule

// File: rtl/sio_master_chk.sv
module sio_master_chk
    import sio_pkg::*;
#(
    parameter int PINS = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            go,
    input logic            ser_clk,
    input logic            ser_load,
    input logic            ser_dout,
    input logic            bus_we,
    input logic [1:0]      bus_addr,
    input logic [31:0]     bus_wdata,
    input logic [PINS-1:0] in_value,
    input logic [PINS-1:0] out_latch
);
    // R4: with no frames allowed, the serial lines settle to idle
    p_idle_when_off_r4: assert property (@(posedge clk) disable iff (rst)
        !go |=> (ser_clk && !ser_load && !ser_dout));

    // R5: strobe only while the serial clock is high
    p_strobe_clk_high_r5: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> ser_clk);

    // R6: data holds across the rising serial edge
    p_dout_holds_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_dout));

    // R8: captured inputs publish only as a new frame opens
    p_value_at_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(in_value) |-> $rose(ser_load));

    // R9: a value-word write lands in the latch one edge later
    p_latch_write_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_VALUE) |=> (out_latch == $past(bus_wdata[PINS-1:0])));
endmodule

bind sio_shift_master sio_master_chk #(.PINS(PINS)) u_chk (
    .clk(clk), .rst(rst), .go(go), .ser_clk(ser_clk), .ser_load(ser_load),
    .ser_dout(ser_dout), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .in_value(in_value), .out_latch(out_latch)
);

// File: tb/sim_sio_shift_master.sv
`timescale 1ns/1ps
module sim_sio_shift_master;
    localparam int CNT_W = 4;
    localparam int MAXG  = 4;
    localparam int NPINS = 8 * MAXG;
    localparam logic [31:0] CMASK = 32'hFFFF_0001 | (((32'd1 << CNT_W) - 1) << 6);
    localparam logic [31:0] PMASK = (NPINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NPINS) - 1);

    logic clk = 1'b0, rst = 1'b1;
    logic bus_we = 1'b0, ser_din = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic ser_clk, ser_load, ser_dout;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [1:0]  rot = 2'd0;

    always #4 clk = ~clk;

    sio_shift_master #(.CNT_W(CNT_W), .MAX_GROUPS(MAXG)) u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_clk(ser_clk),
        .ser_load(ser_load), .ser_dout(ser_dout), .ser_din(ser_din)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_ctrl, m_latch, m_val, m_snap, m_rx;
    bit m_act;
    int m_p, m_D, m_N;

    task automatic m_start(int g);
        m_act  = 1;
        m_p    = 0;
        m_D    = int'(m_ctrl[31:16]);
        m_N    = 8 * g;
        m_snap = m_latch;
        m_rx   = '0;
    endtask

    always @(posedge clk) begin
        int cnt, g, h, k;
        if (rst) begin
            m_ctrl = '0; m_latch = '0; m_val = '0; m_act = 0; m_p = 0;
        end else begin
            cnt = int'((m_ctrl >> 6) & ((32'd1 << CNT_W) - 1));
            g   = (cnt > MAXG) ? MAXG : cnt;
            if (!m_ctrl[0] || g == 0) m_act = 0;
            else if (!m_act) m_start(g);
            else begin
                m_p++;
                if (m_p == (2 + 2 * m_N) * (m_D + 1)) begin
                    m_val = m_rx;
                    m_start(g);
                end else if (m_p % (m_D + 1) == 0) begin
                    h = m_p / (m_D + 1);
                    if (h >= 2 && ((h - 2) % 2) == 1) begin
                        k = (h - 2) / 2;
                        m_rx[m_N - 1 - k] = ser_din;
                    end
                end
            end
            if (bus_we && bus_addr == 2'd0) m_ctrl  = bus_wdata & CMASK;
            if (bus_we && bus_addr == 2'd1) m_latch = bus_wdata & PMASK;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs every clock, away from the edge
    always @(posedge clk) begin
        int h, k;
        logic e_clk, e_load, e_dout;
        logic [31:0] e_rd;
        #3;
        if (!rst && !finished) begin
            e_clk = 1; e_load = 0; e_dout = 0;
            if (m_act) begin
                h = m_p / (m_D + 1);
                if (h < 2) e_load = 1;
                else begin
                    k = h - 2;
                    e_clk  = logic'(k % 2);
                    e_dout = m_snap[m_N - 1 - k / 2];
                end
            end
            case (bus_addr)
                2'd0: e_rd = m_ctrl;
                2'd1: e_rd = m_val;
                2'd2: e_rd = m_latch;
                default: e_rd = '0;
            endcase
            chk("R3 R4 ser_clk", 32'(ser_clk), 32'(e_clk));
            chk("R5 R4 ser_load", 32'(ser_load), 32'(e_load));
            chk("R6 R10 ser_dout", 32'(ser_dout), 32'(e_dout));
            chk(bus_addr == 2'd0 ? "R2 ctrl read" :
                bus_addr == 2'd1 ? "R7 R8 value read" : "R9 readback read",
                bus_rdata, e_rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive_idle();
        bus_we   = 1'b0;
        bus_addr = rot;
        rot      = rot + 2'd1;
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ser_din  = lfsr[0];
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive_idle();
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        drive_idle();
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    // write lands exactly on the next frame-boundary edge
    task automatic wr_at_boundary(logic [1:0] a, logic [31:0] d);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            drive_idle();
            if (m_act && m_p == (2 + 2 * m_N) * (m_D + 1) - 1) begin
                bus_we = 1'b1; bus_addr = a; bus_wdata = d;
                break;
            end
        end
    endtask

    function automatic logic [31:0] ctl(int div, int cnt, bit en);
        return (32'(div) << 16) | (32'(cnt) << 6) | 32'(en);
    endfunction

    initial begin
        step(4);
        @(negedge clk);
        rst = 1'b0;
        drive_idle();
        bus_addr = 2'd0;
        #1;
        chk("R1 ser_clk", 32'(ser_clk), 32'd1);
        chk("R1 ser_load", 32'(ser_load), 32'd0);
        chk("R1 ser_dout", 32'(ser_dout), 32'd0);
        chk("R1 ctrl", bus_rdata, 32'd0);
        step(3);
        wr(2'd1, 32'hA5C3_1E69);
        wr(2'd0, ctl(0, 1, 1));          // R3 divider 0, one group
        step(60);
        wr(2'd1, 32'h0F0F_3355);         // R10 latch change mid-frame
        step(40);
        wr(2'd0, ctl(2, 2, 1));          // R10 divider and count mid-frame
        step(230);
        wr_at_boundary(2'd1, 32'h1234_5678); // R8 R9 write on boundary edge
        step(120);
        wr_at_boundary(2'd0, ctl(1, 7, 1));  // R6 count saturates at MAXG
        step(300);
        wr(2'd0, ctl(1, 7, 0));          // R4 R8 disable mid-frame
        step(30);
        wr(2'd0, ctl(0, 0, 1));          // R4 zero count
        step(30);
        wr(2'd0, ctl(0, 3, 1));
        step(120);
        wr(2'd0, 32'hFFFF_FFFF);         // R2 unused bits drop
        step(50);
        wr(2'd3, 32'hFFFF_FFFF);         // R9 unmapped word reads zero
        step(20);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule